// File: doc/BRIEF.md
# AES-128 On-the-Fly Round Key Generator

This block supplies the AES-128 round keys one round at a time, next to an encryption datapath that runs its rounds at the same pace. A start pulse loads the 128-bit cipher key, which is presented at once as the round-0 key. Each following step pulse replaces the held key with the next round key and advances the round index, so the key for round N is on the output while the datapath works on round N.

Each new key is computed only from the key currently held in the register; the eleven keys are never all stored together. The first word of the new key mixes the previous first word with a rotated and substituted copy of the previous last word and a per-round constant. The three remaining words form a chained XOR. The S-box is built from logic inside the block: a GF(2^8) inverse followed by the affine map.

Top module: `aes128_rkey_gen`

## Requirements
- R1: While rst_n is low at a rising clock edge, the next outputs are round_key = 0 and round_idx = 0.
- R2: With rst_n high and start high at a rising edge, round_key becomes cipher_key and round_idx becomes 0. This applies even when step is also high, because start takes priority over step.
- R3: With rst_n high, start low, step high and round_idx below 10, round_idx increases by one and round_key becomes the expansion of the held key for round round_idx+1.
- R4: Word 0 of a new key (bits 127:96) equals old word 0 XOR SubWord(RotWord(old word 3)) XOR {rcon, 24'h0}. Old word 3 is bits 31:0. RotWord moves the most significant byte to the least significant position. SubWord applies the AES S-box to each byte.
- R5: For words 1 to 3, with word k at bits 127-32k down to 96-32k, new word k equals new word k-1 XOR old word k.
- R6: The round constants used to produce rounds 1 through 10 are, in hex, 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36.
- R7: A step while round_idx is 10 leaves round_key and round_idx unchanged.
- R8: With rst_n high and both start and step low, round_key and round_idx hold their values.
- R9: For cipher key 2b7e151628aed2a6abf7158809cf4f3c, the round 1 key is a0fafe1788542cb123a339392a6c7605 and the round 10 key is d014f9a8c9ee2589e13f0cc8b6630ca6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Loads cipher_key as the round-0 key and clears the index |
| step | input | 1 | Advances to the next round key |
| cipher_key | input | 128 | Cipher key; word 0 is in the top bits |
| round_key | output | 128 | Key for the current round |
| round_idx | output | 4 | Current round number, 0 to 10 |

## Verification
The two hardest things to reach from the ports are the saturated state at round 10 and the check that each round constant is correct on its own. Random step pulses reach round 10 only when a start pulse does not come first. For this reason the bench makes start pulses rare, and directed runs step all ten rounds on purpose and then step again. A wrong constant would be hidden inside the full-key comparison. To expose it, the bench takes each observed new word 0 and removes the old word 0 and the substituted, rotated old word 3, which leaves the constant alone. It then compares that constant with the listed value for each round, using a zero key and the standard key.

// File: rtl/rkg_pkg.sv
// Package: shared widths, word type and GF(2^8) helpers for the round key generator.
// Assumes the AES field polynomial x^8 + x^4 + x^3 + x + 1.
package rkg_pkg;
    localparam int KEY_W  = 128;
    localparam int WORD_W = 32;
    localparam int NWORDS = KEY_W / WORD_W;

    typedef logic [WORD_W-1:0] word_t;

    // Multiply a field element by x.
    function automatic logic [7:0] gf_xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    // General field multiply, shift-and-add.
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction
endpackage

// File: rtl/rkg_sbox.sv
// Module: combinational AES S-box for one byte.
// Computes the field inverse as a^254 (zero maps to zero), then the affine map.
module rkg_sbox
    import rkg_pkg::*;
(
    input  logic [7:0] din,
    output logic [7:0] dout
);
    logic [7:0] p2, p3, p6, p12, p15, p30, p60, p120, p240, inv;

    // Power chain to a^254, which is the multiplicative inverse.
    always_comb begin
        p2   = gf_mul(din, din);
        p3   = gf_mul(p2, din);
        p6   = gf_mul(p3, p3);
        p12  = gf_mul(p6, p6);
        p15  = gf_mul(p12, p3);
        p30  = gf_mul(p15, p15);
        p60  = gf_mul(p30, p30);
        p120 = gf_mul(p60, p60);
        p240 = gf_mul(p120, p120);
        inv  = gf_mul(gf_mul(p240, p12), p2);
    end

    // Affine map: XOR of four left rotations plus the constant 0x63.
    always_comb begin
        dout = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
             ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    end
endmodule

// File: rtl/rkg_word_sub.sv
// Module: rotates a 32-bit word left by one byte, then substitutes every byte.
// Byte 0 is the most significant byte.
module rkg_word_sub
    import rkg_pkg::*;
(
    input  word_t din,
    output word_t dout
);
    word_t rot;

    // Move the top byte to the bottom.
    always_comb rot = {din[23:0], din[31:24]};

    // One S-box per byte lane.
    for (genvar b = 0; b < WORD_W / 8; b++) begin : g_lane
        rkg_sbox u_sbox (
            .din  (rot[8*b +: 8]),
            .dout (dout[8*b +: 8])
        );
    end
endmodule

// File: rtl/rkg_rcon.sv
// Module: round constant for the round being produced (1..ROUNDS).
// Computed by repeated doubling in the field; the input value 0 is never used.
module rkg_rcon
    import rkg_pkg::*;
#(
    parameter int ROUNDS = 10,
    localparam int IDX_W = $clog2(ROUNDS + 1)
) (
    input  logic [IDX_W-1:0] rnd,
    output logic [7:0]       rcon
);
    // Double once for each round after the first.
    always_comb begin
        rcon = 8'h01;
        for (int i = 2; i <= ROUNDS; i++) begin
            if (i <= int'(rnd)) rcon = gf_xtime(rcon);
        end
    end
endmodule

// File: rtl/rkg_next.sv
// Module: builds one round key from the previous key and a round constant.
// Word 0 occupies the top 32 bits. Purely combinational.
module rkg_next
    import rkg_pkg::*;
(
    input  logic [KEY_W-1:0] prev_key,
    input  logic [7:0]       rcon,
    output logic [KEY_W-1:0] next_key
);
    word_t old_w [NWORDS];
    word_t new_w [NWORDS];
    word_t mixed;

    // Split the previous key into words.
    for (genvar k = 0; k < NWORDS; k++) begin : g_split
        assign old_w[k] = prev_key[KEY_W-1-WORD_W*k -: WORD_W];
    end

    rkg_word_sub u_sub (
        .din  (old_w[NWORDS-1]),
        .dout (mixed)
    );

    // First word takes the substituted word and the constant.
    assign new_w[0] = old_w[0] ^ mixed ^ {rcon, 24'h000000};

    // The remaining words form a chained XOR.
    for (genvar k = 1; k < NWORDS; k++) begin : g_chain
        assign new_w[k] = new_w[k-1] ^ old_w[k];
    end

    for (genvar k = 0; k < NWORDS; k++) begin : g_join
        assign next_key[KEY_W-1-WORD_W*k -: WORD_W] = new_w[k];
    end
endmodule

// File: rtl/aes128_rkey_gen.sv
// Module: on-the-fly AES-128 round key generator.
// start loads the cipher key as round 0; each step produces the next key,
// saturating at ROUNDS. Reset is synchronous and active low; start beats step.
module aes128_rkey_gen
    import rkg_pkg::*;
#(
    parameter int ROUNDS = 10,
    localparam int IDX_W = $clog2(ROUNDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             step,
    input  logic [KEY_W-1:0] cipher_key,
    output logic [KEY_W-1:0] round_key,
    output logic [IDX_W-1:0] round_idx
);
    logic [IDX_W-1:0] idx_inc;
    logic [7:0]       rcon;
    logic [KEY_W-1:0] key_nx;
    logic             at_last;

    // Index of the round the next step would produce, and the saturation flag.
    always_comb begin
        idx_inc = round_idx + 1'b1;
        at_last = (round_idx == IDX_W'(ROUNDS));
    end

    rkg_rcon #(.ROUNDS(ROUNDS)) u_rcon (
        .rnd  (idx_inc),
        .rcon (rcon)
    );

    rkg_next u_next (
        .prev_key (round_key),
        .rcon     (rcon),
        .next_key (key_nx)
    );

    // Key and index registers: reset, load, advance or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            round_key <= '0;
            round_idx <= '0;
        end else if (start) begin
            round_key <= cipher_key;
            round_idx <= '0;
        end else if (step && !at_last) begin
            round_key <= key_nx;
            round_idx <= idx_inc;
        end
    end
endmodule

// File: rtl/aes128_rkey_gen_chk.sv
// Module: property checker bound to aes128_rkey_gen.
module aes128_rkey_gen_chk
    import rkg_pkg::*;
#(
    parameter int ROUNDS = 10,
    localparam int IDX_W = $clog2(ROUNDS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             step,
    input logic [KEY_W-1:0] cipher_key,
    input logic [KEY_W-1:0] round_key,
    input logic [IDX_W-1:0] round_idx
);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (round_key == '0 && round_idx == '0));

    a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (round_key == $past(cipher_key) && round_idx == '0));

    a_r3_index_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && step && round_idx < IDX_W'(ROUNDS))
            |=> round_idx == $past(round_idx) + 1'b1);

    a_r5_chain_word1: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && step && round_idx < IDX_W'(ROUNDS))
            |=> ((round_key[95:64] ^ round_key[127:96]) == $past(round_key[95:64])));

    a_r7_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && round_idx == IDX_W'(ROUNDS))
            |=> ($stable(round_key) && round_idx == IDX_W'(ROUNDS)));

    a_r8_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !step) |=> ($stable(round_key) && $stable(round_idx)));

    a_r3_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        round_idx <= IDX_W'(ROUNDS));
endmodule

bind aes128_rkey_gen aes128_rkey_gen_chk #(.ROUNDS(ROUNDS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .step       (step),
    .cipher_key (cipher_key),
    .round_key  (round_key),
    .round_idx  (round_idx)
);

// File: tb/aes128_rkey_gen_test.sv
// Bench: directed corner cases plus seeded random stimulus, checked against
// a model built from an S-box table that the bench generates itself.
module aes128_rkey_gen_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         step = 1'b0;
    logic [127:0] cipher_key = '0;
    logic [127:0] round_key;
    logic [3:0]   round_idx;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0]   tb_sbox [256];
    logic [127:0] m_key = '0;
    logic [3:0]   m_idx = '0;

    aes128_rkey_gen uut (
        .clk(clk), .rst_n(rst_n), .start(start), .step(step),
        .cipher_key(cipher_key), .round_key(round_key), .round_idx(round_idx)
    );

    always #5 clk = ~clk;

    // Build the S-box by walking the field with generator 3 and its inverse.
    function automatic void build_sbox();
        logic [7:0] p, q, x;
        p = 8'h01; q = 8'h01;
        do begin
            p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1B : 8'h00);
            q = q ^ {q[6:0], 1'b0};
            q = q ^ {q[5:0], 2'b00};
            q = q ^ {q[3:0], 4'h0};
            if (q[7]) q = q ^ 8'h09;
            x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
            tb_sbox[p] = x ^ 8'h63;
        end while (p != 8'h01);
        tb_sbox[0] = 8'h63;
    endfunction

    function automatic logic [7:0] lit_rcon(input int r);
        case (r)
            1: return 8'h01;  2: return 8'h02;  3: return 8'h04;  4: return 8'h08;
            5: return 8'h10;  6: return 8'h20;  7: return 8'h40;  8: return 8'h80;
            9: return 8'h1B;  default: return 8'h36;
        endcase
    endfunction

    function automatic logic [31:0] subrot(input logic [31:0] w);
        return {tb_sbox[w[23:16]], tb_sbox[w[15:8]], tb_sbox[w[7:0]], tb_sbox[w[31:24]]};
    endfunction

    function automatic logic [127:0] model_next(input logic [127:0] k, input int r);
        logic [31:0] a, b, c, d;
        a = k[127:96] ^ subrot(k[31:0]) ^ {lit_rcon(r), 24'h0};
        b = a ^ k[95:64];
        c = b ^ k[63:32];
        d = c ^ k[31:0];
        return {a, b, c, d};
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle, update the model, sample after the edge.
    task automatic tick(input logic rn, input logic st, input logic sp, input logic [127:0] k);
        string tag;
        rst_n = rn; start = st; step = sp; cipher_key = k;
        if (!rn) begin
            m_key = '0; m_idx = '0; tag = "R1";
        end else if (st) begin
            m_key = k; m_idx = '0; tag = "R2";
        end else if (sp && m_idx < 4'd10) begin
            m_key = model_next(m_key, int'(m_idx) + 1); m_idx = m_idx + 4'd1; tag = "R3";
        end else if (sp) begin
            tag = "R7";
        end else begin
            tag = "R8";
        end
        @(negedge clk);
        check({tag, " key"}, round_key, m_key);
        check({tag, " idx"}, {124'h0, round_idx}, {124'h0, m_idx});
    endtask

    // Step through all rounds and recover each constant from the ports (R6).
    task automatic rcon_walk(input logic [127:0] k);
        logic [127:0] prev;
        tick(1'b1, 1'b1, 1'b0, k);
        for (int r = 1; r <= 10; r++) begin
            prev = round_key;
            tick(1'b1, 1'b0, 1'b1, k);
            check("R6 rcon", {96'h0, round_key[127:96] ^ prev[127:96] ^ subrot(prev[31:0])},
                  {96'h0, lit_rcon(r), 24'h0});
            check("R5 chain", {96'h0, round_key[31:0]},
                  {96'h0, round_key[63:32] ^ prev[31:0]});
        end
    endtask

    localparam logic [127:0] STD_KEY = 128'h2b7e151628aed2a6abf7158809cf4f3c;

    initial begin
        logic [127:0] rk;
        build_sbox();
        void'($urandom(32'd20240611));
        @(negedge clk);
        check("R1 key", round_key, 128'h0);
        tick(1'b0, 1'b0, 1'b0, STD_KEY);
        tick(1'b1, 1'b1, 1'b1, STD_KEY);          // R2 start beats step
        tick(1'b1, 1'b0, 1'b1, STD_KEY);
        check("R9 round1", round_key, 128'ha0fafe1788542cb123a339392a6c7605);
        check("R4 word0", {96'h0, round_key[127:96]}, {96'h0, 32'ha0fafe17});
        for (int i = 0; i < 9; i++) tick(1'b1, 1'b0, 1'b1, STD_KEY);
        check("R9 round10", round_key, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
        tick(1'b1, 1'b0, 1'b1, STD_KEY);          // R7 saturated step
        check("R7 key", round_key, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
        tick(1'b1, 1'b0, 1'b0, '0);               // R8 idle
        rcon_walk('0);
        tick(1'b1, 1'b1, 1'b0, '0);
        tick(1'b1, 1'b0, 1'b1, '0);
        check("R4 zero key", {96'h0, round_key[127:96]}, {96'h0, 32'h62636363});
        rcon_walk(STD_KEY);
        tick(1'b0, 1'b0, 1'b1, STD_KEY);          // R1 reset mid-run
        for (int i = 0; i < 4000; i++) begin
            rk = {$urandom, $urandom, $urandom, $urandom};
            tick(($urandom % 200) != 0, ($urandom % 24) == 0, ($urandom % 3) != 0, rk);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule